// File: doc/BRIEF.md
# Circular Change-of-Flow Trace Buffer

This block keeps a short history of program flow so that a debug controller can rebuild the path the core took before it stopped. It watches the retirement interface of the core. For every retired instruction it sees the instruction address, a change-of-flow flag, a conditional flag, a taken flag and the branch target. From these it keeps twelve 17-bit entries in a circular store. Each entry holds a 16-bit address and an invalid bit.

The slot under the pointer always tracks the most recently executed address. Every change of flow commits that slot and moves the pointer forward. A branch that is taken also writes its target into the newly current slot. A conditional branch that falls through writes no target and is marked with the invalid bit instead.

Debug mode is an input. While it is high, the recorded history is frozen. The debug controller then pulls entries one at a time through a single read strobe, and every read moves the pointer forward by one. The first read after entering debug returns the oldest entry. The twelfth read returns the last executed address and leaves the pointer where it started.

Top module: `cof_trace_buffer`

## Requirements
- R1: A synchronous active-high reset clears all twelve entries, the pointer, `rd_valid` and `rd_data` to zero.
- R2: Outside debug mode, a retired instruction whose change-of-flow flag is low overwrites the current slot with {invalid=0, address}, and the pointer does not move.
- R3: Outside debug mode, a change of flow that is unconditional, or conditional and taken, writes {invalid=0, branch address} into the current slot. The pointer then advances by one, modulo 12, and the target is written as {invalid=0, target} into the new current slot.
- R4: Outside debug mode, a conditional change of flow that is not taken writes {invalid=1, branch address} into the current slot. The pointer advances by one, and no target is written.
- R5: Each entry is presented as bit 16 = invalid and bits 15:0 = address.
- R6: In debug mode, a read strobe first advances the pointer by one, wrapping from 11 to 0. It then returns the entry at the new pointer on `rd_data`, with `rd_valid` high for exactly the next cycle.
- R7: After debug entry, successive reads return the entries from oldest to newest. The twelfth read returns the last executed address. Twelve reads restore the pointer, so a second pass of twelve reads returns the same sequence.
- R8: In debug mode, retirement activity is ignored, including in a cycle that also carries a read strobe. Entries and pointer change only through reads, and `rd_data` holds its value between reads.
- R9: Outside debug mode, the read strobe is ignored: `rd_valid` stays low and the pointer does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| debug_mode | input | 1 | High while the core is halted in debug |
| ret_valid | input | 1 | An instruction retires this cycle |
| ret_pc | input | 16 | Address of the retiring instruction |
| ret_cof | input | 1 | Retiring instruction is a change of flow |
| ret_cond | input | 1 | The change of flow is conditional |
| ret_taken | input | 1 | The conditional change of flow is taken |
| ret_target | input | 16 | Target address of the change of flow |
| rd_strobe | input | 1 | Read request from the debug controller |
| rd_valid | output | 1 | `rd_data` carries a fresh entry this cycle |
| rd_data | output | 17 | Entry read: bit 16 invalid, bits 15:0 address |

## Verification
A retirement and a read strobe can arrive in the same cycle. The bench drives both in one cycle, once with debug mode high and once with it low. With debug mode high, the read must advance and return the entry the model predicts, and the retirement must leave no trace: all twelve following reads still match the frozen model. With debug mode low, the retirement must be recorded, and the read must produce no `rd_valid` pulse and no pointer movement. A later full pass of reads judges this by returning the expected order.

// File: rtl/cof_trace_pkg.sv
`timescale 1ns/1ps
package cof_trace_pkg;
    localparam int ADDR_W = 16;
    localparam int DEPTH  = 12;
    localparam int PTR_W  = $clog2(DEPTH);

    typedef struct packed {
        logic              inv;
        logic [ADDR_W-1:0] addr;
    } trace_entry_t;

    localparam int ENTRY_W = $bits(trace_entry_t);

    function automatic logic [PTR_W-1:0] slot_after(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction
endpackage

// File: rtl/cof_trace_ptr.sv
`timescale 1ns/1ps
module cof_trace_ptr
    import cof_trace_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    output logic [PTR_W-1:0] ptr,
    output logic [PTR_W-1:0] ptr_nxt
);
    assign ptr_nxt = slot_after(ptr);

    always_ff @(posedge clk) begin
        if (rst)
            ptr <= '0;
        else if (adv)
            ptr <= ptr_nxt;
    end
endmodule

// File: rtl/cof_trace_store.sv
`timescale 1ns/1ps
module cof_trace_store
    import cof_trace_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we_cur,
    input  logic [PTR_W-1:0] idx_cur,
    input  trace_entry_t     din_cur,
    input  logic             we_tgt,
    input  logic [PTR_W-1:0] idx_tgt,
    input  trace_entry_t     din_tgt,
    input  logic [PTR_W-1:0] rd_idx,
    output trace_entry_t     rd_entry
);
    trace_entry_t slots [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                slots[i] <= '0;
            else if (we_tgt && idx_tgt == PTR_W'(i))
                slots[i] <= din_tgt;
            else if (we_cur && idx_cur == PTR_W'(i))
                slots[i] <= din_cur;
        end
    end

    always_comb begin
        rd_entry = '0;
        for (int i = 0; i < DEPTH; i++)
            if (rd_idx == PTR_W'(i))
                rd_entry = slots[i];
    end
endmodule

// File: rtl/cof_trace_buffer.sv
`timescale 1ns/1ps
module cof_trace_buffer
    import cof_trace_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               debug_mode,
    input  logic               ret_valid,
    input  logic [ADDR_W-1:0]  ret_pc,
    input  logic               ret_cof,
    input  logic               ret_cond,
    input  logic               ret_taken,
    input  logic [ADDR_W-1:0]  ret_target,
    input  logic               rd_strobe,
    output logic               rd_valid,
    output logic [ENTRY_W-1:0] rd_data
);
    logic             live, rd_go, is_branch, fell_through, adv;
    logic             we_tgt;
    logic [PTR_W-1:0] ptr, ptr_nxt;
    trace_entry_t     din_cur, din_tgt, rd_entry;

    assign live         = ret_valid & ~debug_mode;
    assign rd_go        = rd_strobe & debug_mode;
    assign is_branch    = live & ret_cof;
    assign fell_through = ret_cond & ~ret_taken;
    assign adv          = is_branch | rd_go;
    assign we_tgt       = is_branch & ~fell_through;

    always_comb begin
        din_cur.inv  = ret_cof & fell_through;
        din_cur.addr = ret_pc;
        din_tgt.inv  = 1'b0;
        din_tgt.addr = ret_target;
    end

    cof_trace_ptr u_ptr (
        .clk     (clk),
        .rst     (rst),
        .adv     (adv),
        .ptr     (ptr),
        .ptr_nxt (ptr_nxt)
    );

    cof_trace_store u_store (
        .clk      (clk),
        .rst      (rst),
        .we_cur   (live),
        .idx_cur  (ptr),
        .din_cur  (din_cur),
        .we_tgt   (we_tgt),
        .idx_tgt  (ptr_nxt),
        .din_tgt  (din_tgt),
        .rd_idx   (ptr_nxt),
        .rd_entry (rd_entry)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_go;
            if (rd_go)
                rd_data <= rd_entry;
        end
    end
endmodule

// File: rtl/cof_trace_checker.sv
`timescale 1ns/1ps
module cof_trace_checker
    import cof_trace_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               debug_mode,
    input logic               ret_valid,
    input logic               ret_cof,
    input logic               rd_strobe,
    input logic               rd_valid,
    input logic [ENTRY_W-1:0] rd_data,
    input logic [PTR_W-1:0]   ptr
);
    a_r6_valid_follows_read: assert property (@(posedge clk) disable iff (rst)
        (debug_mode && rd_strobe) |=> rd_valid);

    a_r9_no_valid_without_read: assert property (@(posedge clk) disable iff (rst)
        !(debug_mode && rd_strobe) |=> !rd_valid);

    a_r6_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
        (debug_mode && rd_strobe && ptr == PTR_W'(DEPTH - 1)) |=> ptr == '0);

    a_r6_ptr_in_range: assert property (@(posedge clk) disable iff (rst)
        ptr < PTR_W'(DEPTH));

    a_r8_frozen_between_reads: assert property (@(posedge clk) disable iff (rst)
        (debug_mode && !rd_strobe) |=> ($stable(ptr) && $stable(rd_data)));

    a_r2_plain_keeps_ptr: assert property (@(posedge clk) disable iff (rst)
        (!debug_mode && ret_valid && !ret_cof) |=> $stable(ptr));

    a_r9_idle_read_keeps_ptr: assert property (@(posedge clk) disable iff (rst)
        (!debug_mode && !(ret_valid && ret_cof)) |=> $stable(ptr));
endmodule

bind cof_trace_buffer cof_trace_checker i_chk (
    .clk        (clk),
    .rst        (rst),
    .debug_mode (debug_mode),
    .ret_valid  (ret_valid),
    .ret_cof    (ret_cof),
    .rd_strobe  (rd_strobe),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data),
    .ptr        (ptr)
);

// File: tb/test_cof_trace_buffer.sv
`timescale 1ns/1ps
module test_cof_trace_buffer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        debug_mode = 1'b0;
    logic        ret_valid = 1'b0;
    logic [15:0] ret_pc = '0;
    logic        ret_cof = 1'b0;
    logic        ret_cond = 1'b0;
    logic        ret_taken = 1'b0;
    logic [15:0] ret_target = '0;
    logic        rd_strobe = 1'b0;
    logic        rd_valid;
    logic [16:0] rd_data;

    always #2 clk = ~clk;

    cof_trace_buffer i_cof_trace_buffer (
        .clk(clk), .rst(rst), .debug_mode(debug_mode), .ret_valid(ret_valid),
        .ret_pc(ret_pc), .ret_cof(ret_cof), .ret_cond(ret_cond),
        .ret_taken(ret_taken), .ret_target(ret_target), .rd_strobe(rd_strobe),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    int          vectors = 0;
    int          miscompares = 0;
    bit          finished = 1'b0;
    logic [16:0] mdl [12];
    int          mptr = 0;
    logic [16:0] expq [$];
    string       tagq [$];

    function automatic int nxt(input int p);
        return (p == 11) ? 0 : p + 1;
    endfunction

    task automatic check(input string req, input logic [16:0] act, input logic [16:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // Monitor: pops one expected entry per rd_valid pulse.
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            if (expq.size() == 0)
                check("R9 unexpected rd_valid", 17'h1, 17'h0);
            else
                check(tagq.pop_front(), rd_data, expq.pop_front());
        end
    end

    task automatic model_retire(input logic [15:0] pc, input logic cof, input logic cond,
                                input logic taken, input logic [15:0] tgt);
        if (!cof) begin
            mdl[mptr] = {1'b0, pc};
        end else begin
            mdl[mptr] = {cond & ~taken, pc};
            mptr = nxt(mptr);
            if (!(cond && !taken))
                mdl[mptr] = {1'b0, tgt};
        end
    endtask

    task automatic drive(input bit rv, input logic [15:0] pc, input logic cof, input logic cond,
                         input logic taken, input logic [15:0] tgt, input bit rd, input string tag);
        @(negedge clk);
        ret_valid = rv; ret_pc = pc; ret_cof = cof; ret_cond = cond;
        ret_taken = taken; ret_target = tgt; rd_strobe = rd;
        if (!debug_mode && rv)
            model_retire(pc, cof, cond, taken, tgt);
        if (debug_mode && rd) begin
            mptr = nxt(mptr);
            expq.push_back(mdl[mptr]);
            tagq.push_back(tag);
        end
    endtask

    task automatic idle();
        drive(1'b0, '0, 1'b0, 1'b0, 1'b0, '0, 1'b0, "");
    endtask

    task automatic set_debug(input logic v);
        @(negedge clk);
        ret_valid = 1'b0; rd_strobe = 1'b0; debug_mode = v;
    endtask

    task automatic read_pass(input string tag);
        for (int k = 0; k < 12; k++)
            drive(1'b0, '0, 1'b0, 1'b0, 1'b0, '0, 1'b1, tag);
        idle();
        idle();
    endtask

    task automatic fill(input int n, input logic [15:0] base);
        for (int i = 0; i < n; i++) begin
            logic [15:0] pc;
            pc = base + 16'(i * 4);
            case (i % 4)
                0: drive(1'b1, pc, 1'b0, 1'b0, 1'b0, '0, 1'b0, "");
                1: drive(1'b1, pc, 1'b1, 1'b0, 1'b0, pc + 16'h40, 1'b0, "");
                2: drive(1'b1, pc, 1'b1, 1'b1, 1'b0, pc + 16'h80, 1'b0, "");
                default: drive(1'b1, pc, 1'b1, 1'b1, 1'b1, pc + 16'hC0, 1'b0, "");
            endcase
        end
        idle();
    endtask

    initial begin
        for (int i = 0; i < 12; i++) mdl[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 rd_valid after reset", {16'h0, rd_valid}, 17'h0);
        check("R1 rd_data after reset", rd_data, 17'h0);

        set_debug(1'b1);
        read_pass("R1 entries zero after reset");
        set_debug(1'b0);

        // Directed record: plain, uncond, not-taken, taken, plain
        drive(1'b1, 16'h0100, 1'b0, 1'b0, 1'b0, '0, 1'b0, "");
        drive(1'b1, 16'h0101, 1'b1, 1'b0, 1'b0, 16'h0200, 1'b0, "");
        drive(1'b1, 16'h0200, 1'b0, 1'b0, 1'b0, '0, 1'b0, "");
        drive(1'b1, 16'h0201, 1'b1, 1'b1, 1'b0, 16'h0999, 1'b0, "");
        drive(1'b1, 16'h0202, 1'b1, 1'b1, 1'b1, 16'h0300, 1'b0, "");
        drive(1'b1, 16'h0300, 1'b0, 1'b0, 1'b0, '0, 1'b0, "");
        drive(1'b1, 16'h0301, 1'b0, 1'b0, 1'b0, '0, 1'b0, "");
        idle();
        set_debug(1'b1);
        read_pass("R2 R3 R4 R5 directed entries");
        set_debug(1'b0);

        // Long mixed history that wraps several times
        fill(30, 16'h1000);
        set_debug(1'b1);
        read_pass("R7 oldest to newest after wrap");
        read_pass("R7 second pass same order");

        // Retirement during debug must be ignored
        drive(1'b1, 16'hBEEF, 1'b1, 1'b0, 1'b0, 16'hDEAD, 1'b0, "");
        drive(1'b1, 16'hCAFE, 1'b0, 1'b0, 1'b0, '0, 1'b0, "");
        idle();
        read_pass("R8 retire ignored in debug");

        // Same cycle read and retire in debug
        drive(1'b1, 16'h7777, 1'b1, 1'b1, 1'b1, 16'h8888, 1'b1, "R8 R6 read with retire same cycle");
        idle();
        idle();
        read_pass("R8 contents after same-cycle retire");
        set_debug(1'b0);

        // Read outside debug is ignored, retire in same cycle still recorded
        fill(9, 16'h4000);
        drive(1'b1, 16'h5000, 1'b1, 1'b0, 1'b0, 16'h5100, 1'b1, "");
        @(negedge clk);
        check("R9 no rd_valid outside debug", {16'h0, rd_valid}, 17'h0);
        rd_strobe = 1'b0; ret_valid = 1'b0;
        drive(1'b0, '0, 1'b0, 1'b0, 1'b0, '0, 1'b1, "");
        @(negedge clk);
        check("R9 no rd_valid on lone read", {16'h0, rd_valid}, 17'h0);
        rd_strobe = 1'b0;
        idle();
        set_debug(1'b1);
        read_pass("R9 R7 pointer unmoved by ignored reads");
        set_debug(1'b0);

        repeat (4) idle();
        check("R6 all reads answered", 17'(expq.size()), 17'h0);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #400000;
        if (!finished) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule